// File: doc/BRIEF.md
# Flash Command State Engine

This block is a clocked behavioural model of the control logic of a byte-wide flash memory whose array is divided into 256-byte sectors. A host drives active-low chip enable, write enable and output enable together with an address and a data byte. The engine samples these pins on the system clock and recognises write pulses and read pulses from them. Write pulses carry command bytes, which the engine decodes. Every change to the array takes two steps: a setup byte, then an execute write.

Once an erase or program has been accepted, the engine goes busy for a fixed number of clock cycles, counted by an internal counter. During that interval a read returns status instead of array data, and the host polls this status to learn when the operation has finished. An identification mode returns two fixed code bytes. A software protect flag, set at reset, blocks every modification. Seven reads at fixed addresses clear the flag or set it again. The array is a small bank of byte registers.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset every array byte reads FFh, the engine is in read mode, the protect flag is set, and `dq_oe` is low while the bus is idle.
- R2: `dq_oe` is high only while `ce_n` and `oe_n` are both low.
- R3: Seven completed reads whose low 16 address bits are 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h and then 041Ah clear the protect flag. The same six reads followed by 040Ah set the flag. A read that breaks the order restarts matching, with 1823h counting as a new first step.
- R4: While the protect flag is set, the setup bytes 20h and 10h are ignored and the array is left unchanged.
- R5: Program is 10h followed by one write of address and data. After programming, the addressed byte holds its old value ANDed with the data.
- R6: Erase is 20h followed by D0h written to any address in the sector, where the sector is address bits 18 to 8. All 256 bytes of that sector become FFh and other sectors are unchanged.
- R7: FFh written after either setup byte cancels the operation and returns to read mode with the array unchanged. A byte other than D0h after 20h also returns to read mode without any change.
- R8: 90h enters identification mode. A read at address 0 returns BFh and a read at address 1 returns 04h. Other addresses return array data. FFh, and any other command, leaves the mode.
- R9: While busy, a read returns bit 7 equal to the complement of bit 7 of the loaded data (the loaded data is FFh for an erase) and bit 6 equal to a toggle flag. The toggle flag is cleared when the operation starts and inverts after each completed read. Bits 5 to 0 are zero.
- R10: The busy interval lasts PROG_CYC clock cycles for a program and ERASE_CYC for an erase, counted from the clock edge that sees the execute write end. After that, reads return true data.
- R11: Writes that arrive while busy are ignored, except FFh during an erase, which ends the erase at once and returns to read mode.
- R12: The write address is taken in the first cycle in which both `ce_n` and `we_n` are low. The write data is taken in the last such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data written by the host |
| dq_out | output | 8 | Read data or busy status |
| dq_oe | output | 1 | Output enable for a tri-state data pad |

## Verification
The checks assume that the host never overlaps a read pulse with a write pulse. They also assume that every strobe stays low for at least one full clock cycle, so that the start and the end of each pulse fall on different clock edges. The bench changes all pins on the falling clock edge, holds every strobe low for one or two cycles, and leaves idle cycles between transactions. One directed write moves the address and the data while the pulse is still active, to show which cycle each one is taken from.

// File: rtl/fce_pkg.sv
`timescale 1ns/1ps
package fce_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_ID,
        ST_ERS_SETUP,
        ST_PGM_SETUP,
        ST_ERS_BUSY,
        ST_PGM_BUSY
    } state_t;

    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_PGM     = 8'h10;
    localparam logic [7:0] CMD_ABORT   = 8'hFF;
    localparam logic [7:0] CMD_ID      = 8'h90;
    localparam logic [7:0] ID_MAKER    = 8'hBF;
    localparam logic [7:0] ID_PART     = 8'h04;

    localparam int SEC_SHIFT = 8;

    localparam logic [15:0] SEQ_UNLOCK = 16'h041A;
    localparam logic [15:0] SEQ_LOCK   = 16'h040A;
    localparam logic [2:0]  SEQ_LAST   = 3'd6;

    // shared prefix of the protect and unprotect read sequences
    function automatic logic [15:0] seq_addr(input logic [2:0] idx);
        case (idx)
            3'd0:    seq_addr = 16'h1823;
            3'd1:    seq_addr = 16'h1820;
            3'd2:    seq_addr = 16'h1822;
            3'd3:    seq_addr = 16'h0418;
            3'd4:    seq_addr = 16'h041B;
            3'd5:    seq_addr = 16'h0419;
            default: seq_addr = SEQ_UNLOCK;
        endcase
    endfunction

    function automatic logic [7:0] status_byte(input logic poll7, input logic tog);
        status_byte = {~poll7, tog, 6'b0};
    endfunction

endpackage

// File: rtl/fce_bus_sampler.sv
`timescale 1ns/1ps
module fce_bus_sampler #(
    parameter int WA_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            oe_n,
    input  logic [WA_W-1:0] wr_addr_in,
    input  logic [15:0]     rd_addr_in,
    input  logic [7:0]      din,
    output logic            wr_stb,
    output logic [WA_W-1:0] wr_addr,
    output logic [7:0]      wr_data,
    output logic            rd_end,
    output logic [15:0]     rd_addr
);
    logic wr_act, rd_act, wr_act_q, rd_act_q;

    assign wr_act = !ce_n && !we_n;
    assign rd_act = !ce_n && !oe_n && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            rd_addr  <= '0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
            if (wr_act && !wr_act_q) wr_addr <= wr_addr_in;  // later falling strobe
            if (wr_act)              wr_data <= din;         // last active cycle wins
            if (rd_act)              rd_addr <= rd_addr_in;
        end
    end

    assign wr_stb = wr_act_q && !wr_act;
    assign rd_end = rd_act_q && !rd_act;
endmodule

// File: rtl/fce_protect_seq.sv
`timescale 1ns/1ps
module fce_protect_seq
    import fce_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_end,
    input  logic [15:0] rd_addr,
    output logic        prot
);
    logic [2:0] idx;
    logic       first_hit;

    assign first_hit = (rd_addr == seq_addr(3'd0));

    always_ff @(posedge clk) begin
        if (rst) begin
            prot <= 1'b1;
            idx  <= '0;
        end else if (rd_end) begin
            if (idx == SEQ_LAST) begin
                if (rd_addr == SEQ_UNLOCK)    prot <= 1'b0;
                else if (rd_addr == SEQ_LOCK) prot <= 1'b1;
                idx <= first_hit ? 3'd1 : 3'd0;
            end else if (rd_addr == seq_addr(idx)) begin
                idx <= idx + 3'd1;
            end else begin
                idx <= first_hit ? 3'd1 : 3'd0;
            end
        end
    end
endmodule

// File: rtl/fce_array.sv
`timescale 1ns/1ps
module fce_array
    import fce_pkg::*;
#(
    parameter int MEM_BYTES = 1024
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pgm_en,
    input  logic [$clog2(MEM_BYTES)-1:0] pgm_idx,
    input  logic [7:0]                   pgm_data,
    input  logic                         ers_en,
    input  logic [$clog2(MEM_BYTES)-SEC_SHIFT-1:0] ers_sec,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_idx,
    output logic [7:0]                   rd_data
);
    localparam int IDX_W = $clog2(MEM_BYTES);
    localparam int SEC_W = IDX_W - SEC_SHIFT;

    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                if (ers_en && (SEC_W'(i >> SEC_SHIFT) == ers_sec)) mem[i] <= 8'hFF;
            end
            if (pgm_en) mem[pgm_idx] <= mem[pgm_idx] & pgm_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/flash_cmd_engine.sv
`timescale 1ns/1ps
module flash_cmd_engine
    import fce_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int MEM_BYTES = 1024,
    parameter int ERASE_CYC = 800000,
    parameter int PROG_CYC  = 8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);
    localparam int IDX_W   = $clog2(MEM_BYTES);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             wr_stb, rd_end, prot;
    logic [IDX_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [15:0]      rd_addr;

    state_t             st;
    logic [CNT_W-1:0]   cnt;
    logic               poll, tog;
    logic [IDX_W-1:0]   pend_addr;
    logic [7:0]         pend_data;
    logic [IDX_W-SEC_SHIFT-1:0] ers_sec;
    logic               busy, last_cyc, ers_abort, pgm_en, ers_en;
    logic [7:0]         arr_data;

    fce_bus_sampler #(.WA_W(IDX_W)) u_bus (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .wr_addr_in(addr[IDX_W-1:0]), .rd_addr_in(addr[15:0]), .din(dq_in),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_end(rd_end), .rd_addr(rd_addr)
    );

    fce_protect_seq u_prot (
        .clk(clk), .rst(rst), .rd_end(rd_end), .rd_addr(rd_addr), .prot(prot)
    );

    assign busy      = (st == ST_ERS_BUSY) || (st == ST_PGM_BUSY);
    assign last_cyc  = (cnt == CNT_W'(1));
    assign ers_abort = (st == ST_ERS_BUSY) && wr_stb && (wr_data == CMD_ABORT);
    assign pgm_en    = (st == ST_PGM_BUSY) && last_cyc;
    assign ers_en    = (st == ST_ERS_BUSY) && last_cyc && !ers_abort;

    fce_array #(.MEM_BYTES(MEM_BYTES)) u_arr (
        .clk(clk), .rst(rst),
        .pgm_en(pgm_en), .pgm_idx(pend_addr), .pgm_data(pend_data),
        .ers_en(ers_en), .ers_sec(ers_sec),
        .rd_idx(addr[IDX_W-1:0]), .rd_data(arr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_READ;
            cnt       <= '0;
            poll      <= 1'b0;
            tog       <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
            ers_sec   <= '0;
        end else begin
            if (busy && rd_end) tog <= ~tog;
            case (st)
                ST_READ, ST_ID: begin
                    if (wr_stb) begin
                        case (wr_data)
                            CMD_ERASE: st <= prot ? ST_READ : ST_ERS_SETUP;
                            CMD_PGM:   st <= prot ? ST_READ : ST_PGM_SETUP;
                            CMD_ID:    st <= ST_ID;
                            CMD_ABORT: st <= ST_READ;
                            default:   ;
                        endcase
                    end
                end
                ST_ERS_SETUP: begin
                    if (wr_stb) begin
                        if (wr_data == CMD_CONFIRM) begin
                            st      <= ST_ERS_BUSY;
                            cnt     <= CNT_W'(ERASE_CYC);
                            poll    <= 1'b1;
                            tog     <= 1'b0;
                            ers_sec <= wr_addr[IDX_W-1:SEC_SHIFT];
                        end else begin
                            st <= ST_READ;
                        end
                    end
                end
                ST_PGM_SETUP: begin
                    if (wr_stb) begin
                        if (wr_data == CMD_ABORT) begin
                            st <= ST_READ;
                        end else begin
                            st        <= ST_PGM_BUSY;
                            cnt       <= CNT_W'(PROG_CYC);
                            poll      <= wr_data[7];
                            tog       <= 1'b0;
                            pend_addr <= wr_addr;
                            pend_data <= wr_data;
                        end
                    end
                end
                default: begin
                    if (ers_abort || last_cyc) begin
                        st  <= ST_READ;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        if (busy)                                      dq_out = status_byte(poll, tog);
        else if (st == ST_ID && addr == '0)            dq_out = ID_MAKER;
        else if (st == ST_ID && addr == ADDR_W'(1))    dq_out = ID_PART;
        else                                           dq_out = arr_data;
    end

    assign dq_oe = !ce_n && !oe_n;
endmodule

// File: rtl/fce_checker.sv
`timescale 1ns/1ps
module fce_checker
    import fce_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dq_out,
    input logic              dq_oe,
    input state_t            st,
    input logic              prot,
    input logic [CNT_W-1:0]  cnt
);
    logic busy;
    assign busy = (st == ST_ERS_BUSY) || (st == ST_PGM_BUSY);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prot && st == ST_READ));

    assert_busy_unprot_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(prot));

    assert_cnt_live_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt != '0));

    assert_busy_exit_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == CNT_W'(1)) |=> (st == ST_READ));

    assert_id_code_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ID && dq_oe && addr == '0) |-> (dq_out == ID_MAKER));

    assert_status_low_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && dq_oe) |-> (dq_out[5:0] == 6'b0));
endmodule

bind flash_cmd_engine fce_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe),
    .st(st), .prot(prot), .cnt(cnt)
);

// File: tb/sim_flash_cmd_engine.sv
`timescale 1ns/1ps
module sim_flash_cmd_engine;
    localparam int AW    = 19;
    localparam int ERS   = 40;
    localparam int PGM   = 12;
    localparam int WAITC = ERS + 6;
    localparam int NV    = 56;

    logic clk = 1'b0, rst = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dq_out;
    logic       dq_oe;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    flash_cmd_engine #(.ADDR_W(AW), .MEM_BYTES(1024), .ERASE_CYC(ERS), .PROG_CYC(PGM)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // op: 0 write, 1 read and compare, 2 wait for any operation to finish
    typedef struct packed {
        logic [1:0]  op;
        logic [18:0] a;
        logic [7:0]  d;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VT [NV] = '{
        '{2'd1, 19'h00010, 8'h00, 8'hFF, 4'd1},   // R1 erased after reset
        '{2'd0, 19'h00000, 8'h10, 8'h00, 4'd4},   // R4 protected
        '{2'd0, 19'h00010, 8'h5A, 8'h00, 4'd4},
        '{2'd2, 19'h00000, 8'h00, 8'h00, 4'd4},
        '{2'd1, 19'h00010, 8'h00, 8'hFF, 4'd4},
        '{2'd1, 19'h01823, 8'h00, 8'hFF, 4'd3},   // R3 unprotect sequence
        '{2'd1, 19'h01820, 8'h00, 8'hFF, 4'd3},
        '{2'd1, 19'h01822, 8'h00, 8'hFF, 4'd3},
        '{2'd1, 19'h00418, 8'h00, 8'hFF, 4'd3},
        '{2'd1, 19'h0041B, 8'h00, 8'hFF, 4'd3},
        '{2'd1, 19'h00419, 8'h00, 8'hFF, 4'd3},
        '{2'd1, 19'h0041A, 8'h00, 8'hFF, 4'd3},
        '{2'd0, 19'h00000, 8'h10, 8'h00, 4'd5},   // R5 program
        '{2'd0, 19'h00010, 8'h5A, 8'h00, 4'd5},
        '{2'd2, 19'h00000, 8'h00, 8'h00, 4'd5},
        '{2'd1, 19'h00010, 8'h00, 8'h5A, 4'd5},
        '{2'd0, 19'h00000, 8'h10, 8'h00, 4'd5},   // R5 AND with old value
        '{2'd0, 19'h00010, 8'hF0, 8'h00, 4'd5},
        '{2'd2, 19'h00000, 8'h00, 8'h00, 4'd5},
        '{2'd1, 19'h00010, 8'h00, 8'h50, 4'd5},
        '{2'd0, 19'h00000, 8'h10, 8'h00, 4'd5},
        '{2'd0, 19'h00105, 8'h33, 8'h00, 4'd5},
        '{2'd2, 19'h00000, 8'h00, 8'h00, 4'd5},
        '{2'd1, 19'h00105, 8'h00, 8'h33, 4'd5},
        '{2'd0, 19'h00000, 8'h90, 8'h00, 4'd8},   // R8 identification
        '{2'd1, 19'h00000, 8'h00, 8'hBF, 4'd8},
        '{2'd1, 19'h00001, 8'h00, 8'h04, 4'd8},
        '{2'd1, 19'h00010, 8'h00, 8'h50, 4'd8},
        '{2'd0, 19'h00000, 8'hFF, 8'h00, 4'd8},
        '{2'd1, 19'h00000, 8'h00, 8'hFF, 4'd8},
        '{2'd0, 19'h00000, 8'h20, 8'h00, 4'd7},   // R7 abort erase setup
        '{2'd0, 19'h00000, 8'hFF, 8'h00, 4'd7},
        '{2'd0, 19'h00010, 8'hD0, 8'h00, 4'd7},
        '{2'd2, 19'h00000, 8'h00, 8'h00, 4'd7},
        '{2'd1, 19'h00010, 8'h00, 8'h50, 4'd7},
        '{2'd0, 19'h00000, 8'h10, 8'h00, 4'd7},   // R7 abort program setup
        '{2'd0, 19'h00010, 8'hFF, 8'h00, 4'd7},
        '{2'd2, 19'h00000, 8'h00, 8'h00, 4'd7},
        '{2'd1, 19'h00010, 8'h00, 8'h50, 4'd7},
        '{2'd0, 19'h00000, 8'h20, 8'h00, 4'd6},   // R6 sector erase
        '{2'd0, 19'h00077, 8'hD0, 8'h00, 4'd6},
        '{2'd2, 19'h00000, 8'h00, 8'h00, 4'd6},
        '{2'd1, 19'h00010, 8'h00, 8'hFF, 4'd6},
        '{2'd1, 19'h000FF, 8'h00, 8'hFF, 4'd6},
        '{2'd1, 19'h00105, 8'h00, 8'h33, 4'd6},
        '{2'd1, 19'h01823, 8'h00, 8'hFF, 4'd3},   // R3 protect sequence
        '{2'd1, 19'h01820, 8'h00, 8'hFF, 4'd3},
        '{2'd1, 19'h01822, 8'h00, 8'hFF, 4'd3},
        '{2'd1, 19'h00418, 8'h00, 8'hFF, 4'd3},
        '{2'd1, 19'h0041B, 8'h00, 8'hFF, 4'd3},
        '{2'd1, 19'h00419, 8'h00, 8'hFF, 4'd3},
        '{2'd1, 19'h0040A, 8'h00, 8'hFF, 4'd3},
        '{2'd0, 19'h00000, 8'h10, 8'h00, 4'd3},
        '{2'd0, 19'h00200, 8'h00, 8'h00, 4'd3},
        '{2'd2, 19'h00000, 8'h00, 8'h00, 4'd3},
        '{2'd1, 19'h00200, 8'h00, 8'hFF, 4'd3}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_skew(input logic [AW-1:0] a1, input logic [7:0] d1,
                           input logic [AW-1:0] a2, input logic [7:0] d2);
        @(negedge clk); addr = a1; din = d1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); addr = a2; din = d2;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); d = dq_out; oe = dq_oe;
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic oe;
        rd(a, d, oe);
        check(req, d, exp);
    endtask

    task automatic unlock();
        logic [7:0] d;
        logic oe;
        rd(19'h01823, d, oe); rd(19'h01820, d, oe); rd(19'h01822, d, oe);
        rd(19'h00418, d, oe); rd(19'h0041B, d, oe); rd(19'h00419, d, oe);
        rd(19'h0041A, d, oe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle oe", {7'b0, dq_oe}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (VT[i].op)
                2'd0: wr(VT[i].a, VT[i].d);
                2'd1: rd_chk($sformatf("R%0d vec %0d", VT[i].req, i), VT[i].a, VT[i].exp);
                default: repeat (WAITC) @(negedge clk);
            endcase
        end

        // R2 output enable gating
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); check("R2 ce only", {7'b0, dq_oe}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); check("R2 oe only", {7'b0, dq_oe}, 8'h00);
        ce_n = 1'b0;
        @(negedge clk); check("R2 both low", {7'b0, dq_oe}, 8'h01);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);

        unlock();

        // R9 busy status: data 01h gives DQ7=1, toggle starts at 0
        wr(19'h00000, 8'h10);
        wr(19'h00300, 8'h01);
        rd_chk("R9 status first", 19'h00300, 8'h80);
        rd_chk("R9 status toggled", 19'h00300, 8'hC0);
        repeat (PGM + 4) @(negedge clk);
        rd_chk("R10 program done", 19'h00300, 8'h01);

        // R10 exact erase length: busy at cycle 38, data after cycle 40
        wr(19'h00000, 8'h20);
        wr(19'h00300, 8'hD0);
        repeat (ERS - 4) @(negedge clk);
        rd_chk("R10 still busy", 19'h00300, 8'h00);
        rd_chk("R10 erase done", 19'h00300, 8'hFF);

        // R11 writes while busy ignored, FFh aborts erase
        wr(19'h00000, 8'h20);
        wr(19'h00280, 8'hD0);
        wr(19'h00000, 8'h10);
        rd_chk("R11 still busy", 19'h00280, 8'h00);
        wr(19'h00000, 8'hFF);
        wr(19'h00005, 8'h00);
        repeat (PGM + 4) @(negedge clk);
        rd_chk("R11 no stray program", 19'h00005, 8'hFF);
        wr(19'h00000, 8'h10);
        wr(19'h00000, 8'h3C);
        repeat (PGM + 4) @(negedge clk);
        rd_chk("R11 accepted after abort", 19'h00000, 8'h3C);

        // R12 address from first active cycle, data from last
        wr(19'h00000, 8'h10);
        wr_skew(19'h00040, 8'h00, 19'h00041, 8'hA5);
        repeat (PGM + 4) @(negedge clk);
        rd_chk("R12 first address", 19'h00040, 8'hA5);
        rd_chk("R12 other address", 19'h00041, 8'hFF);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule